// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer behind a 32-bit register port. A down-counter is clocked through a programmable prescaler. The prescaler advances only on cycles where the tick input is high, and that input is nominally a 32768 Hz enable. When the enabled counter runs out, the block raises a one-cycle reset request and then holds still until software reloads it. The timeout is therefore load × divisor ticks, which is load × divisor / 32768 seconds at the nominal tick rate.

Every register write must carry the unlock key 0x1234 in data bits [31:16]. A write with any other upper half is dropped, and only bits [15:0] are stored. Divisor and load writes go into shadow registers. Software activates them with a toggle handshake on the refresh register. That register holds three 2-bit groups: one for the divisor, one for the counter and load value, and one for an interrupt value. A group acts only when it moves between code 1 and code 2. Because the refresh register reads back, XOR-ing it with 0x3F and writing the result fires all groups at once.

Top module: `keyed_wdt`

## Requirements
- R1: A write whose data bits [31:16] differ from 0x1234 changes no register and no counting state.
- R2: Keyed writes store data bits [15:0]. Reads return the stored value zero-extended at the following offsets: divisor config 0x04, load 0x08, refresh 0x18 (6 bits), start 0x1C. Any other offset reads 0.
- R3: Writes to config (0x04) or load (0x08) do not change the active divisor or the active load value.
- R4: When refresh bits [3:2] move from 1 to 2 or from 2 to 1, the load shadow is copied into the active load value, the down-counter is loaded from it, the prescaler restarts and any expiry is cleared.
- R5: When refresh bits [5:4] move from 1 to 2 or from 2 to 1, the active divisor becomes config bits [15:8] plus one (range 1 to 256), and the prescaler restarts.
- R6: A refresh write that sets a group to 0 or 3, or leaves it unchanged, has no effect for that group.
- R7: While enabled, the counter decrements once per divisor tick-cycles. rst_req rises exactly load × divisor tick-cycles after a reload. A load of 0 expires after one divisor period. Cycles with tick low do not count.
- R8: rst_req lasts one cycle. After it, counting stops and no further request occurs until a reload.
- R9: Start bit 0 enables counting. While it is clear, no reset request occurs.
- R10: A keyed start write that sets bit 0 while it was clear reloads the counter from the active load value and restarts the prescaler.
- R11: After reset the config reads 0x0F00 (divisor 16), load reads 0xFFFF, refresh reads 0x15, start reads 0, and rst_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler advance enable (nominal 32768 Hz strobe) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data: key in [31:16], payload in [15:0] |
| rdata | output | 32 | Read data for addr (combinational) |
| rst_req | output | 1 | One-cycle expiry reset request |

## Verification
Assertions in the RTL check several rules on every cycle. A wrong key leaves every register untouched. Config, load and non-toggling refresh writes leave the active values alone. The prescaler never passes the active divisor. The counter steps down by exactly one on each prescaler wrap. The reset request is a single cycle, and nothing moves while expired or disabled. The exact timeout of load × divisor ticks for several load and divisor pairs can only be shown by the bench's scenarios. The same holds for the shadow-versus-active effect seen through the timeout, the ordering of group codes across several writes, and the pause of counting while tick is low.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned PAY_W  = 16;
    localparam int unsigned DIV_W  = 8;
    localparam int unsigned DIV_LSB = 8;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned GRP_W  = 6;
    localparam logic [15:0] UNLOCK_KEY = 16'h1234;

    localparam logic [4:0] OFF_CFG   = 5'h04;
    localparam logic [4:0] OFF_LOAD  = 5'h08;
    localparam logic [4:0] OFF_REFR  = 5'h18;
    localparam logic [4:0] OFF_START = 5'h1C;

    localparam logic [GRP_W-1:0] REFR_RESET = 6'h15;

    typedef struct packed {
        logic cfg;
        logic cnt;
    } refresh_hit_t;

    function automatic logic grp_flip(input logic [1:0] old_c, input logic [1:0] new_c);
        return ((old_c == 2'd1) && (new_c == 2'd2)) || ((old_c == 2'd2) && (new_c == 2'd1));
    endfunction

    function automatic refresh_hit_t refresh_decode(input logic [GRP_W-1:0] old_v,
                                                    input logic [GRP_W-1:0] new_v);
        refresh_hit_t h;
        h.cfg = grp_flip(old_v[5:4], new_v[5:4]);
        h.cnt = grp_flip(old_v[3:2], new_v[3:2]);
        return h;
    endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int unsigned DIV_RESET  = 16,
    parameter logic [CNT_W-1:0] LOAD_RESET = 16'hFFFF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [4:0]          addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    output logic [DIV_W-1:0]    act_div,
    output logic                reload,
    output logic [CNT_W-1:0]    reload_val,
    output logic                div_upd,
    output logic                enable
);
    localparam logic [DIV_W-1:0] DIV_RST_M1 = DIV_W'(DIV_RESET - 1);
    localparam logic [PAY_W-1:0] CFG_RST = PAY_W'({DIV_RST_M1, {DIV_LSB{1'b0}}});

    logic [PAY_W-1:0] cfg_sh, load_sh, start_r, act_load;
    logic [GRP_W-1:0] refr_r;
    logic             key_ok, wr_ok, refr_wr, start_rise;
    logic [PAY_W-1:0] pay;
    refresh_hit_t     hit;

    assign key_ok  = (wdata[REG_W-1:PAY_W] == UNLOCK_KEY);
    assign wr_ok   = wr_en && key_ok;
    assign pay     = wdata[PAY_W-1:0];
    assign refr_wr = wr_ok && (addr == OFF_REFR);

    always_comb begin
        hit = refresh_decode(refr_r, pay[GRP_W-1:0]);
        if (!refr_wr) hit = '0;
    end

    assign start_rise = wr_ok && (addr == OFF_START) && pay[0] && !start_r[0];
    assign reload     = hit.cnt || start_rise;
    assign reload_val = hit.cnt ? load_sh : act_load;
    assign div_upd    = hit.cfg;
    assign enable     = start_r[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_sh   <= CFG_RST;
            load_sh  <= LOAD_RESET;
            refr_r   <= REFR_RESET;
            start_r  <= '0;
            act_div  <= DIV_RST_M1;
            act_load <= LOAD_RESET;
        end else if (wr_ok) begin
            unique case (addr)
                OFF_CFG:   cfg_sh  <= pay;
                OFF_LOAD:  load_sh <= pay;
                OFF_REFR: begin
                    refr_r <= pay[GRP_W-1:0];
                    if (hit.cfg) act_div  <= cfg_sh[DIV_LSB +: DIV_W];
                    if (hit.cnt) act_load <= load_sh;
                end
                OFF_START: start_r <= pay;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            OFF_CFG:   rdata = REG_W'(cfg_sh);
            OFF_LOAD:  rdata = REG_W'(load_sh);
            OFF_REFR:  rdata = REG_W'(refr_r);
            OFF_START: rdata = REG_W'(start_r);
            default:   rdata = '0;
        endcase
    end

    // R1: a write with the wrong key leaves every register as it was
    assert_badkey_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !key_ok) |=> ($stable(cfg_sh) && $stable(load_sh) && $stable(refr_r)
                                && $stable(start_r) && $stable(act_div) && $stable(act_load)));

    // R3: shadow writes leave the active values alone
    assert_shadow_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == OFF_CFG || addr == OFF_LOAD)) |=> ($stable(act_div) && $stable(act_load)));

    // R6: a non-toggling counter group leaves the active load alone
    assert_noflip_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_REFR && !grp_flip(refr_r[3:2], wdata[3:2])) |=> $stable(act_load));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div_m1,
    output logic             wrap
);
    logic [DIV_W-1:0] pcnt;

    assign wrap = run && tick && (pcnt == div_m1) && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear)      pcnt <= '0;
        else if (run && tick)  pcnt <= wrap ? '0 : pcnt + 1'b1;
    end

    // R5: the prescale count never passes the active divisor
    assert_pcnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        pcnt <= div_m1);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] LOAD_RESET = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expired,
    output logic             rst_req
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= LOAD_RESET;
            expired <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (reload) begin
                cnt     <= reload_val;
                expired <= 1'b0;
            end else if (wrap) begin
                if (cnt <= CNT_W'(1)) begin
                    cnt     <= '0;
                    expired <= 1'b1;
                    rst_req <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R8: the request lasts a single cycle
    assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R8: once expired, nothing moves until a reload
    assert_halt_R8: assert property (@(posedge clk) disable iff (rst)
        (expired && !reload) |=> ($stable(cnt) && !rst_req));

    // R7: each prescaler wrap removes exactly one count
    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap && !reload && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int unsigned      DIV_RESET  = 16,
    parameter logic [CNT_W-1:0] LOAD_RESET = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        rst_req
);
    logic [DIV_W-1:0] act_div;
    logic [CNT_W-1:0] reload_val;
    logic             reload, div_upd, enable, expired, wrap, run;

    assign run = enable && !expired;

    kwdt_regs #(.DIV_RESET(DIV_RESET), .LOAD_RESET(LOAD_RESET)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .act_div(act_div), .reload(reload), .reload_val(reload_val),
        .div_upd(div_upd), .enable(enable)
    );

    kwdt_prescaler pre_i (
        .clk(clk), .rst(rst), .tick(tick), .run(run),
        .clear(reload || div_upd), .div_m1(act_div), .wrap(wrap)
    );

    kwdt_counter #(.LOAD_RESET(LOAD_RESET)) cnt_i (
        .clk(clk), .rst(rst), .wrap(wrap), .reload(reload), .reload_val(reload_val),
        .expired(expired), .rst_req(rst_req)
    );

    // R9: a disabled watchdog raises no request in the next cycle
    assert_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !rst_req);
endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int failures = 0;

    localparam logic [4:0] A_CFG = 5'h04, A_LOAD = 5'h08, A_REFR = 5'h18, A_START = 5'h1C;

    // {load[15:0], divisor field[7:0], expected cycles[15:0]}
    localparam int NVEC = 6;
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd5,  8'd2,   16'd15},
        {16'd1,  8'd0,   16'd1},
        {16'd3,  8'd255, 16'd768},
        {16'd10, 8'd1,   16'd20},
        {16'd0,  8'd3,   16'd4},
        {16'd7,  8'd4,   16'd35}
    };

    always #5 clk = ~clk;

    keyed_wdt dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        wr_raw(a, {16'h1234, d});
    endtask

    task automatic rd_reg(input logic [4:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic refresh(input logic [5:0] mask);
        int v;
        rd_reg(A_REFR, v);
        wr_reg(A_REFR, 16'(v) ^ {10'd0, mask});
    endtask

    task automatic restart();
        wr_reg(A_START, 16'h0000);
        wr_reg(A_START, 16'h0001);
    endtask

    task automatic measure(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_req) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, n, w;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd_reg(A_CFG, v);   chk("R11 cfg", v, 32'h0F00);
        rd_reg(A_LOAD, v);  chk("R11 load", v, 32'hFFFF);
        rd_reg(A_REFR, v);  chk("R11 refresh", v, 32'h15);
        rd_reg(A_START, v); chk("R11 start", v, 0);
        chk("R11 rst_req", int'(rst_req), 0);

        // R1 wrong key
        wr_raw(A_CFG, 32'h4321_0500);
        rd_reg(A_CFG, v); chk("R1 cfg after bad key", v, 32'h0F00);
        wr_raw(A_REFR, 32'h0000_002A);
        rd_reg(A_REFR, v); chk("R1 refresh after bad key", v, 32'h15);

        // R2 readback
        wr_raw(A_START, 32'h1234_00A4);
        rd_reg(A_START, v); chk("R2 start readback", v, 32'hA4);
        wr_reg(A_CFG, 16'hBEEF);
        rd_reg(A_CFG, v); chk("R2 cfg readback", v, 32'hBEEF);
        rd_reg(5'h0C, v); chk("R2 unused offset", v, 0);

        // R7 timeout table
        for (int k = 0; k < NVEC; k++) begin
            wr_reg(A_START, 16'h0000);
            wr_reg(A_CFG, {VEC[k][23:16], 8'h00});
            wr_reg(A_LOAD, VEC[k][39:24]);
            refresh(6'h3F);
            wr_reg(A_START, 16'h0001);
            measure(2000, n);
            chk("R7 timeout", n, int'(VEC[k][15:0]));
        end

        // R8 single pulse, then halted
        @(negedge clk); chk("R8 pulse width", int'(rst_req), 0);
        measure(500, n); chk("R8 halted after expiry", n, 0);

        // R3 load shadow not active; R10 restart reloads active value (7*5)
        wr_reg(A_LOAD, 16'd40);
        restart();
        measure(2000, n); chk("R3/R10 load shadow inactive", n, 35);

        // R4 counter group toggle activates load 40 (40*5)
        refresh(6'h0C);
        measure(2000, n); chk("R4 counter group reload", n, 200);

        // R3 config shadow, R5 config group
        wr_reg(A_CFG, 16'h0000);
        restart();
        measure(2000, n); chk("R3 cfg shadow inactive", n, 200);
        refresh(6'h30);
        restart();
        measure(2000, n); chk("R5 config group divisor", n, 40);

        // R6 illegal / unchanged codes in the counter group
        wr_reg(A_LOAD, 16'd9);
        rd_reg(A_REFR, v);
        w = (v & 32'h33);
        wr_reg(A_REFR, 16'(w));                 // to 0
        wr_reg(A_REFR, 16'(w | 32'h0C));        // to 3
        wr_reg(A_REFR, 16'(w | 32'h0C));        // unchanged
        wr_reg(A_REFR, 16'(w | 32'h04));        // 3 -> 1
        restart();
        measure(2000, n); chk("R6 no effect codes", n, 40);
        wr_reg(A_REFR, 16'(w | 32'h08));        // 1 -> 2
        measure(2000, n); chk("R6/R4 legal toggle", n, 9);

        // R9 disable halts
        restart();
        repeat (3) @(negedge clk);
        wr_reg(A_START, 16'h0000);
        measure(300, n); chk("R9 disabled no request", n, 0);

        // R7 tick low does not count
        tick = 1'b0;
        wr_reg(A_START, 16'h0001);
        measure(200, n); chk("R7 tick low holds", n, 0);
        tick = 1'b1;
        measure(2000, n); chk("R7 resumes full count", n, 9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule